// File: doc/BRIEF.md
# I2C Slave Address Matcher with Maskable Compare

This block is the address front end of an I2C slave. It watches SCL and SDA and finds START, repeated START and STOP conditions. It shifts in the address byte, plus a second byte when 10-bit addressing is selected. The received address is checked against a programmed own address, and any bit that the mask marks is left out of the check. When the address matches, the block pulls SDA low for the acknowledge clock and sets a sticky interrupt flag. If stretching is enabled, it then holds SCL low until software releases it.

Two mask schemes are available. The wide scheme uses a byte-wide mask register, with one mask bit per address bit. The narrow scheme uses a five-bit control field: four of its bits mask address bits 5 to 2, and its lowest bit masks address bit 1 in 7-bit addressing, or bits 1 and 0 together in 10-bit addressing. General-call recognition can be switched on or off. Software reaches everything through a small write/read register port. Writes are synchronous and reads are combinational.

Register map (3-bit address): 0 = own address low byte; 1 = control, with bit 0 ten-bit, bit 1 narrow-mask select, bit 2 general-call enable, bit 3 stretch enable, and bits 5:4 the two upper 10-bit address bits; 2 = wide mask; 3 = narrow mask field in bits 4:0; 4 = command, write-only, with bit 0 clearing the interrupt and bit 1 releasing the stretch, and it reads as 0.

Top module: `i2c_am_top`

## Requirements
- R1: After reset, the wide mask reads 0xFF. The own address, control and narrow mask read 0x00, and sda_pull_o, scl_hold_o and irq_o are low.
- R2: In 7-bit addressing, bits 7:1 of the first byte (sent MSB first) are compared with own-address bits 7:1. A bit with its mask set is ignored, and a bit with its mask clear must match. Bit 0 of the byte is the read/write flag and is never compared.
- R3: With the wide mask in 7-bit addressing, wide-mask bit 0 has no effect on the result.
- R4: With the narrow mask, field bits 4:1 mask own-address bits 5:2 one for one. Address bits 7:6 always need an exact match.
- R5: With the narrow mask, field bit 0 masks own-address bit 1 alone in 7-bit addressing, and bits 1 and 0 together in 10-bit addressing.
- R6: In 10-bit addressing, a first byte equal to 11110, then the two upper own-address bits, then the read/write flag, is acknowledged without raising the interrupt. The second byte is then compared in full with the own-address low byte under the mask. Only a match on the second byte raises the interrupt.
- R7: With general call enabled, the first byte 0x00 is acknowledged and raises the interrupt. With it disabled, that byte is neither acknowledged nor flagged.
- R8: On a match, sda_pull_o is high for the whole ninth clock, starting while SCL is low after the eighth bit. A byte that does not match gets no pull and no interrupt.
- R9: With stretch enabled, scl_hold_o rises after the ninth clock of a completed match and holds the bus SCL low until a release command is written. With stretch disabled, the block never holds SCL.
- R10: The interrupt stays set until a clear command is written. If a clear and a new match land in the same cycle, the flag ends up set.
- R11: A STOP returns the block to idle in the middle of a byte. A repeated START in the middle of a byte restarts address reception from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus SCL level |
| sda_i | input | 1 | Bus SDA level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| sda_pull_o | output | 1 | High while the block pulls SDA low (acknowledge) |
| scl_hold_o | output | 1 | High while the block holds SCL low (stretch) |
| irq_o | output | 1 | Sticky address-match interrupt |

## Verification
The interrupt flag can be set by the bus and cleared by software in the same cycle, and the two sources are not synchronised with each other. The bench sweeps the clear command across eight consecutive cycles that straddle the falling SCL edge after the eighth address bit, so one offset lands exactly on the set edge. For each offset, it records the flag just before the write edge. If the flag was already up, the clear must win. If not, the flag must still be set afterwards, whether the set arrived in the same cycle or later.

// File: rtl/i2c_am_pkg.sv
`timescale 1ns/1ps
package i2c_am_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HI_W   = 2;
  localparam int unsigned CM_W   = 5;
  localparam int unsigned RA_W   = 3;

  localparam logic [RA_W-1:0] RA_OWN   = 3'd0;
  localparam logic [RA_W-1:0] RA_CTRL  = 3'd1;
  localparam logic [RA_W-1:0] RA_MASK  = 3'd2;
  localparam logic [RA_W-1:0] RA_CMASK = 3'd3;
  localparam logic [RA_W-1:0] RA_CMD   = 3'd4;

  // fixed prefix of a 10-bit address header byte
  localparam logic [4:0] TEN_HDR = 5'b11110;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_ACK, ST_DONE} state_e;

  typedef struct packed {
    logic [HI_W-1:0] own_hi;
    logic            stretch_en;
    logic            gc_en;
    logic            mask5;
    logic            ten_bit;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/i2c_am_regs.sv
`timescale 1ns/1ps
module i2c_am_regs import i2c_am_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RA_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] own_o,
  output ctrl_t             ctrl_o,
  output logic [BYTE_W-1:0] mask_o,
  output logic [CM_W-1:0]   cmask_o,
  output logic              clr_irq_o,
  output logic              rel_o
);
  logic [BYTE_W-1:0] own_q, mask_q;
  ctrl_t             ctrl_q;
  logic [CM_W-1:0]   cmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q   <= '0;
      ctrl_q  <= '0;
      mask_q  <= '1;
      cmask_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_OWN:   own_q   <= wdata_i;
        RA_CTRL:  ctrl_q  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        RA_MASK:  mask_q  <= wdata_i;
        RA_CMASK: cmask_q <= wdata_i[CM_W-1:0];
        default: ;
      endcase
    end
  end

  // command register is write-only strobes
  assign clr_irq_o = we_i && (addr_i == RA_CMD) && wdata_i[0];
  assign rel_o     = we_i && (addr_i == RA_CMD) && wdata_i[1];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_OWN:   rdata_o = own_q;
      RA_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
      RA_MASK:  rdata_o = mask_q;
      RA_CMASK: rdata_o[CM_W-1:0] = cmask_q;
      default:  rdata_o = '0;
    endcase
  end

  assign own_o   = own_q;
  assign ctrl_o  = ctrl_q;
  assign mask_o  = mask_q;
  assign cmask_o = cmask_q;
endmodule

// File: rtl/i2c_am_link.sv
`timescale 1ns/1ps
module i2c_am_link #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // SYNC_STAGES synchroniser flops plus one history flop per line
  logic [SYNC_STAGES:0] scl_sh, sda_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_sh[SYNC_STAGES-1];
  assign scl_old = scl_sh[SYNC_STAGES];
  assign sda_now = sda_sh[SYNC_STAGES-1];
  assign sda_old = sda_sh[SYNC_STAGES];

  assign scl_o      = scl_now;
  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_old;
  assign scl_fall_o = ~scl_now & scl_old;
  assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_am_match.sv
`timescale 1ns/1ps
module i2c_am_match import i2c_am_pkg::*; (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              second_i,
  input  logic [BYTE_W-1:0] own_i,
  input  logic [HI_W-1:0]   own_hi_i,
  input  logic              ten_i,
  input  logic              mask5_i,
  input  logic              gc_en_i,
  input  logic [BYTE_W-1:0] mask_i,
  input  logic [CM_W-1:0]   cmask_i,
  output logic              ack_o,
  output logic              final_o
);
  logic [BYTE_W-1:0] eff, diff;

  always_comb begin
    if (mask5_i) begin
      eff = '0;
      for (int i = 2; i < CM_W + 1; i++) eff[i] = cmask_i[i-1];
      eff[1] = cmask_i[0];
      eff[0] = ten_i & cmask_i[0];  // low control widens in 10-bit mode
    end else begin
      eff = mask_i;
    end
  end

  assign diff = (byte_i ^ own_i) & ~eff;

  always_comb begin
    ack_o   = 1'b0;
    final_o = 1'b0;
    if (second_i) begin
      ack_o   = (diff == '0);
      final_o = 1'b1;
    end else if (gc_en_i && byte_i == '0) begin
      ack_o   = 1'b1;
      final_o = 1'b1;
    end else if (ten_i) begin
      ack_o   = (byte_i[BYTE_W-1:1] == {TEN_HDR, own_hi_i});
      final_o = 1'b0;
    end else begin
      ack_o   = (diff[BYTE_W-1:1] == '0);
      final_o = 1'b1;
    end
  end

  always_comb begin
    if (mask5_i && !ten_i && !second_i && (byte_i != '0) &&
        (byte_i[BYTE_W-1] != own_i[BYTE_W-1])) begin
      assert_top_bits_exact_R4: assert (!ack_o);
    end
  end
endmodule

// File: rtl/i2c_am_top.sv
`timescale 1ns/1ps
module i2c_am_top import i2c_am_pkg::*; #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              sda_pull_o,
  output logic              scl_hold_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [BYTE_W-1:0] own_w, mask_w;
  ctrl_t             ctrl_w;
  logic [CM_W-1:0]   cmask_w;
  logic              clr_w, rel_w;

  i2c_am_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .own_o(own_w), .ctrl_o(ctrl_w),
    .mask_o(mask_w), .cmask_o(cmask_w), .clr_irq_o(clr_w), .rel_o(rel_w)
  );

  logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;

  i2c_am_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_w), .stop_o(stop_w)
  );

  state_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] shift_q;
  logic              second_q, ack_pend_q, fin_pend_q, final_q;
  logic              sda_pull_q, hold_q, irq_q;
  logic [BYTE_W-1:0] byte_full;
  logic              m_ack, m_fin;

  assign byte_full = {shift_q, sda_s};

  i2c_am_match u_match (
    .byte_i(byte_full), .second_i(second_q), .own_i(own_w),
    .own_hi_i(ctrl_w.own_hi), .ten_i(ctrl_w.ten_bit), .mask5_i(ctrl_w.mask5),
    .gc_en_i(ctrl_w.gc_en), .mask_i(mask_w), .cmask_i(cmask_w),
    .ack_o(m_ack), .final_o(m_fin)
  );

  logic bus_ev, set_irq, set_hold;
  assign bus_ev   = start_w | stop_w;
  assign set_irq  = (state_q == ST_ADDR) && !bus_ev && scl_fall &&
                    (cnt_q == CNT_FULL) && ack_pend_q && fin_pend_q;
  assign set_hold = (state_q == ST_ACK) && !bus_ev && scl_fall &&
                    final_q && ctrl_w.stretch_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      second_q   <= 1'b0;
      ack_pend_q <= 1'b0;
      fin_pend_q <= 1'b0;
      final_q    <= 1'b0;
      sda_pull_q <= 1'b0;
    end else if (start_w) begin
      state_q    <= ST_ADDR;
      cnt_q      <= '0;
      second_q   <= 1'b0;
      sda_pull_q <= 1'b0;
    end else if (stop_w) begin
      state_q    <= ST_IDLE;
      sda_pull_q <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            shift_q <= {shift_q[BYTE_W-3:0], sda_s};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              ack_pend_q <= m_ack;
              fin_pend_q <= m_fin;
            end
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (ack_pend_q) begin
              state_q    <= ST_ACK;
              sda_pull_q <= 1'b1;
              final_q    <= fin_pend_q;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_pull_q <= 1'b0;
            if (final_q) begin
              state_q <= ST_DONE;
            end else begin
              state_q  <= ST_ADDR;
              cnt_q    <= '0;
              second_q <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // set beats clear when both land together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (set_irq) irq_q <= 1'b1;
    else if (clr_w)   irq_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= 1'b0;
    else if (set_hold) hold_q <= 1'b1;
    else if (rel_w)    hold_q <= 1'b0;
  end

  assign sda_pull_o = sda_pull_q;
  assign scl_hold_o = hold_q;
  assign irq_o      = irq_q;

  assert_pull_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_q) |-> !scl_s);
  assert_irq_with_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> sda_pull_q);
  assert_irq_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !clr_w |=> irq_q);
  assert_hold_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q && !rel_w |=> hold_q);
  assert_hold_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_q) |-> ctrl_w.stretch_en);
endmodule

// File: tb/tb_i2c_am_top.sv
`timescale 1ns/1ps
module tb_i2c_am_top;
  import i2c_am_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pull, hold, irq;
  logic       scl_bus, sda_bus;

  always #2.5 clk = ~clk;

  assign scl_bus = scl_m & ~hold;
  assign sda_bus = sda_m & ~pull;

  i2c_am_top dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sda_pull_o(pull), .scl_hold_o(hold), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;

  // shadow of programmed configuration (reference model state)
  logic [7:0] s_own = '0, s_mask = 8'hFF;
  logic [1:0] s_hi = '0;
  logic [4:0] s_cm = '0;
  bit s_ten = 0, s_m5 = 0, s_gc = 0, s_st = 0;
  bit exp_irq = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ph(); repeat (10) @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic cfg(input logic [7:0] own, input logic [1:0] hi, input bit ten,
                     input bit m5, input bit gc, input bit st,
                     input logic [7:0] mask, input logic [4:0] cm);
    s_own = own; s_hi = hi; s_ten = ten; s_m5 = m5; s_gc = gc; s_st = st;
    s_mask = mask; s_cm = cm;
    wr(RA_OWN, own);
    wr(RA_CTRL, {2'b00, hi, st, gc, m5, ten});
    wr(RA_MASK, mask);
    wr(RA_CMASK, {3'b000, cm});
  endtask

  function automatic bit masked_bit(input int i);
    if (!s_m5) return s_mask[i];
    if (i >= 6) return 1'b0;
    if (i >= 2) return s_cm[i-1];
    if (i == 1) return s_cm[0];
    return s_ten ? s_cm[0] : 1'b0;
  endfunction

  function automatic bit low_ok(input logic [7:0] b, input int lo);
    for (int i = lo; i < 8; i++)
      if (!masked_bit(i) && b[i] != s_own[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit first_ack(input logic [7:0] b);
    if (s_gc && b == 8'h00) return 1'b1;
    if (s_ten) return (b[7:3] == 5'b11110) && (b[2:1] == s_hi);
    return low_ok(b, 1);
  endfunction

  function automatic bit first_final(input logic [7:0] b);
    return (s_gc && b == 8'h00) || !s_ten;
  endfunction

  task automatic b_start();
    sda_m = 1'b1; ph(); scl_m = 1'b1; ph(); sda_m = 1'b0; ph(); scl_m = 1'b0; ph();
  endtask

  task automatic b_stop();
    sda_m = 1'b0; ph(); scl_m = 1'b1; ph(); sda_m = 1'b1; ph();
  endtask

  task automatic b_bit(input bit v);
    sda_m = v; ph(); scl_m = 1'b1; ph(); scl_m = 1'b0; ph();
  endtask

  task automatic b_send(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) b_bit(b[i]);
  endtask

  task automatic b_ninth();
    int w;
    sda_m = 1'b1; scl_m = 1'b1; w = 0;
    while (!scl_bus && w < 1000) begin @(negedge clk); w++; end
    ph(); scl_m = 1'b0; ph();
  endtask

  task automatic clr_irq(input string tag);
    wr(RA_CMD, 8'h01); exp_irq = 0; ph();
    chk(tag, int'(irq), 0);
  endtask

  task automatic run_addr(input logic [7:0] b1, input logic [7:0] b2, input string tag);
    bit e1, f1, e2, hit;
    b_start();
    b_send(b1, 8);
    e1 = first_ack(b1); f1 = first_final(b1);
    chk({tag, " ack"}, int'(pull), int'(e1));
    b_ninth();
    hit = e1 && f1;
    if (e1 && !f1) begin
      chk({tag, " R6 no irq after header"}, int'(irq), int'(exp_irq));
      b_send(b2, 8);
      e2 = low_ok(b2, 0);
      chk({tag, " R6 second ack"}, int'(pull), int'(e2));
      b_ninth();
      hit = e2;
    end
    if (hit) exp_irq = 1;
    chk({tag, " irq"}, int'(irq), int'(exp_irq));
    chk({tag, " R9 hold"}, int'(hold), int'(hit && s_st));
    if (hold) begin
      scl_m = 1'b1; ph();
      chk("R9 scl held low", int'(scl_bus), 0);
      wr(RA_CMD, 8'h02); ph();
      chk("R9 release hold", int'(hold), 0);
      chk("R9 scl free", int'(scl_bus), 1);
      scl_m = 1'b0; ph();
    end
    b_stop();
    chk({tag, " R11 idle pull"}, int'(pull), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    bit pre;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ph();
    // R1 reset state
    rd_chk(RA_OWN, 0, "R1 own");
    rd_chk(RA_CTRL, 0, "R1 ctrl");
    rd_chk(RA_MASK, 255, "R1 mask");
    rd_chk(RA_CMASK, 0, "R1 cmask");
    rd_chk(RA_CMD, 0, "R1 cmd");
    chk("R1 pull", int'(pull), 0);
    chk("R1 hold", int'(hold), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 exact 7-bit compare, R/W excluded
    cfg(8'hA4, 2'b00, 0, 0, 0, 0, 8'h00, 5'h00);
    run_addr(8'hA4, 8'h00, "R2 exact write");
    clr_irq("R10 clear");
    run_addr(8'hA5, 8'h00, "R2 exact read");
    clr_irq("R10 clear");
    run_addr(8'hA6, 8'h00, "R2 mismatch");
    chk("R8 no irq on mismatch", int'(irq), 0);
    // R2 masked bits ignored
    cfg(8'hA4, 2'b00, 0, 0, 0, 0, 8'h0C, 5'h00);
    run_addr(8'hAC, 8'h00, "R2 masked bit3");
    clr_irq("R10 clear");
    run_addr(8'hB4, 8'h00, "R2 unmasked bit4");
    // R3 wide mask bit0 has no effect
    cfg(8'hA4, 2'b00, 0, 0, 0, 0, 8'h01, 5'h00);
    run_addr(8'hA5, 8'h00, "R3 mask0 read");
    clr_irq("R10 clear");
    run_addr(8'hA6, 8'h00, "R3 mask0 no widen");

    // R4 narrow mask bits 5:2 and exact top bits
    cfg(8'hA4, 2'b00, 0, 1, 0, 0, 8'hFF, 5'b00010);
    run_addr(8'hA0, 8'h00, "R4 bit2 masked");
    clr_irq("R10 clear");
    run_addr(8'hAC, 8'h00, "R4 bit3 unmasked");
    cfg(8'hA4, 2'b00, 0, 1, 0, 0, 8'h00, 5'b11111);
    run_addr(8'h9A, 8'h00, "R4 bits5..1 masked");
    clr_irq("R10 clear");
    run_addr(8'h24, 8'h00, "R4 bit7 exact");
    run_addr(8'hE4, 8'h00, "R4 bit6 exact");
    // R5 low control in 7-bit
    cfg(8'hA4, 2'b00, 0, 1, 0, 0, 8'h00, 5'b00001);
    run_addr(8'hA6, 8'h00, "R5 bit1 masked 7b");
    clr_irq("R10 clear");

    // R6 / R5 10-bit addressing
    cfg(8'h3C, 2'b10, 1, 1, 0, 0, 8'h00, 5'b00000);
    run_addr(8'hF4, 8'h3C, "R6 ten match");
    clr_irq("R10 clear");
    run_addr(8'hF4, 8'h3D, "R6 ten low bit0 exact");
    run_addr(8'hF2, 8'h3C, "R6 wrong header");
    cfg(8'h3C, 2'b10, 1, 1, 0, 0, 8'h00, 5'b00001);
    run_addr(8'hF4, 8'h3F, "R5 bits1:0 masked 10b");
    clr_irq("R10 clear");
    run_addr(8'hF4, 8'h38, "R5 bit2 exact 10b");

    // R7 general call
    cfg(8'hA4, 2'b00, 0, 0, 1, 0, 8'h00, 5'h00);
    run_addr(8'h00, 8'h00, "R7 gc enabled");
    clr_irq("R10 clear");
    cfg(8'hA4, 2'b00, 0, 0, 0, 0, 8'h00, 5'h00);
    run_addr(8'h00, 8'h00, "R7 gc disabled");
    chk("R7 gc no irq", int'(irq), 0);

    // R9 stretching on and off
    cfg(8'hA4, 2'b00, 0, 0, 0, 1, 8'h00, 5'h00);
    run_addr(8'hA4, 8'h00, "R9 stretch on");
    clr_irq("R10 clear");
    run_addr(8'hA6, 8'h00, "R9 no stretch on nack");
    cfg(8'hA4, 2'b00, 0, 0, 0, 0, 8'h00, 5'h00);
    run_addr(8'hA4, 8'h00, "R9 stretch off");

    // R10 sticky through later mismatch
    run_addr(8'h12, 8'h00, "R10 sticky");
    chk("R10 still set", int'(irq), 1);
    clr_irq("R10 clear");

    // R11 repeated start mid-byte, stop mid-byte
    b_start(); b_send(8'h12, 4);
    b_start(); b_send(8'hA4, 8);
    chk("R11 restart ack", int'(pull), 1);
    b_ninth(); exp_irq = 1;
    chk("R11 restart irq", int'(irq), 1);
    b_stop();
    clr_irq("R10 clear");
    b_start(); b_send(8'hA4, 3); b_stop();
    chk("R11 stop pull", int'(pull), 0);
    chk("R11 stop irq", int'(irq), 0);
    b_send(8'hA4, 8);
    chk("R11 idle ignores clocks", int'(pull), 0);
    b_stop();
    run_addr(8'hA4, 8'h00, "R11 after stop");
    clr_irq("R10 clear");

    // R10 clear vs set, swept across the set cycle
    for (int k = 0; k < 8; k++) begin
      b_start(); b_send(8'hA4, 7);
      sda_m = 1'b0; ph(); scl_m = 1'b1; ph(); scl_m = 1'b0;
      repeat (k) @(negedge clk);
      pre = irq;
      we = 1'b1; addr = RA_CMD; wdata = 8'h01;
      @(negedge clk); we = 1'b0;
      ph();
      chk($sformatf("R10 same-cycle k=%0d", k), int'(irq), pre ? 0 : 1);
      b_ninth(); b_stop();
      clr_irq("R10 clear");
    end

    summary();
    $finish;
  end
endmodule